// File: doc/BRIEF.md
# YCbCr 4:2:2 Link Packer

This block takes a stream of YCbCr 4:2:2 pixel pairs, each pair made of two luma samples, one blue-difference sample and one red-difference sample of up to 12 bits. It spreads each pair over two consecutive pixel periods on three 8-bit link channels, as used by the 24-bit-per-pixel transport. Every sample is split: its upper byte fills a whole channel and its low nibble shares a fourth byte with another sample. The two chroma samples share the same channel bits and alternate between the two periods.

Samples narrower than 12 bits arrive right-aligned and are left-justified with zero fill, according to a depth select that is captured with each pair. The upstream source offers pairs through a valid/ready handshake. A pair is taken only in the first pixel period, so a continuous stream yields one channel word per clock. A pair flagged as holding a single pixel marks an odd-length line. This sets a sticky error flag, and the missing second luma is sent as zero.

Top module: `ycc422_link_packer`

## Requirements
- R1: After reset, out_valid, out_sol and err_odd are 0 and in_ready is 1.
- R2: in_ready is 1 exactly when the block is in its first pixel period. A pair accepted on a clock edge appears as the first-period word after that edge and the second-period word after the next edge. in_ready is low while the first word is shown, so offers made then are ignored.
- R3: The first-period word (out_phase 0) carries Y0 and Cb. Bits [15:8] hold Y0[11:4], bits [23:16] hold Cb[11:4], bits [3:0] hold Y0[3:0] and bits [7:4] hold Cb[3:0].
- R4: The second-period word (out_phase 1) follows the same layout with Y1 in place of Y0 and Cr in place of Cb.
- R5: in_depth selects the sample width. A value of 0 means 8 bits taken from [7:0]. A value of 1 means 10 bits taken from [9:0]. A value of 2 or 3 means 12 bits. A narrower sample is shifted up to bit 11 with zeros below, and input bits above the selected width are ignored.
- R6: When in_single is set on an accepted pair, err_odd becomes 1 on the next edge and the second-period luma fields are zero.
- R7: err_odd stays 1 until reset.
- R8: out_sol is 1 only on the first-period word of a pair that was accepted with in_sol set.
- R9: When no pair is accepted in the first period, out_valid is 0 on the next cycle. Back-to-back pairs produce one valid word per cycle.
- R10: The depth select is taken at acceptance. A change of in_depth during the second period does not alter the second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pair offered |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_sol | input | 1 | Pair is the first of an active line |
| in_single | input | 1 | Pair holds one pixel only (odd line) |
| in_depth | input | 2 | Sample width select: 0=8, 1=10, 2/3=12 bits |
| in_y0 | input | 12 | First luma sample, right-aligned |
| in_y1 | input | 12 | Second luma sample, right-aligned |
| in_cb | input | 12 | Blue-difference sample, right-aligned |
| in_cr | input | 12 | Red-difference sample, right-aligned |
| out_valid | output | 1 | Channel word valid |
| out_phase | output | 1 | 0 = first pixel period, 1 = second |
| out_sol | output | 1 | Word starts an active line |
| out_data | output | 24 | Channels 2,1,0 at [23:16],[15:8],[7:0] |
| err_odd | output | 1 | Sticky odd-pixel-count error |

## Verification
A phase register stuck or skipped shows up at once: a missing second word, a doubled first word, or in_ready asserted while the first word is shown. Each of these is visible on the cycle right after an acceptance. Wrong latching of the held samples or the depth appears only in the second word, one cycle later, so that word is checked with the depth input and dummy offers disturbed while it is pending. A mis-wired nibble or byte shows on the first word of any pair with non-zero low bits, and random samples make such a pair nearly certain.

// File: rtl/ycc422_pkg.sv
package ycc422_pkg;
    localparam int SAMPLE_W = 12;
    localparam int CH_W     = 8;
    localparam int LOW_W    = SAMPLE_W - CH_W;
    localparam int N_CH     = 3;
    localparam int WORD_W   = N_CH * CH_W;
    localparam int N_SAMP   = 4;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        DEPTH_8   = 2'd0,
        DEPTH_10  = 2'd1,
        DEPTH_12  = 2'd2,
        DEPTH_12B = 2'd3
    } depth_e;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        logic [CH_W-1:0] ch2;
        logic [CH_W-1:0] ch1;
        logic [CH_W-1:0] ch0;
    } word_t;

    // Left-justify a right-aligned sample of the selected width.
    function automatic sample_t justify(input sample_t raw, input depth_e d);
        case (d)
            DEPTH_8:  return raw << (SAMPLE_W - 8);
            DEPTH_10: return raw << (SAMPLE_W - 10);
            default:  return raw;
        endcase
    endfunction
endpackage

// File: rtl/ycc422_justify.sv
module ycc422_justify
    import ycc422_pkg::*;
(
    input  sample_t raw,
    input  depth_e  depth,
    output sample_t padded
);
    assign padded = justify(raw, depth);
endmodule

// File: rtl/ycc422_chan_map.sv
module ycc422_chan_map
    import ycc422_pkg::*;
(
    input  sample_t luma,
    input  sample_t chroma,
    output word_t   word
);
    always_comb begin
        word.ch2 = chroma[SAMPLE_W-1 -: CH_W];
        word.ch1 = luma[SAMPLE_W-1 -: CH_W];
        word.ch0 = {chroma[LOW_W-1:0], luma[LOW_W-1:0]};
    end
endmodule

// File: rtl/ycc422_link_packer.sv
module ycc422_link_packer
    import ycc422_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_sol,
    input  logic                in_single,
    input  logic [1:0]          in_depth,
    input  logic [SAMPLE_W-1:0] in_y0,
    input  logic [SAMPLE_W-1:0] in_y1,
    input  logic [SAMPLE_W-1:0] in_cb,
    input  logic [SAMPLE_W-1:0] in_cr,
    output logic                out_valid,
    output logic                out_phase,
    output logic                out_sol,
    output logic [WORD_W-1:0]   out_data,
    output logic                err_odd
);
    localparam int IDX_Y0 = 0;
    localparam int IDX_Y1 = 1;
    localparam int IDX_CB = 2;
    localparam int IDX_CR = 3;

    phase_e  phase_q;
    sample_t raw   [N_SAMP];
    sample_t pad   [N_SAMP];
    sample_t hold_y1_q;
    sample_t hold_cr_q;
    word_t   word_first;
    word_t   word_second;
    word_t   word_q;
    logic    accept;
    depth_e  depth_in;

    assign depth_in    = depth_e'(in_depth);
    assign raw[IDX_Y0] = in_y0;
    assign raw[IDX_Y1] = in_y1;
    assign raw[IDX_CB] = in_cb;
    assign raw[IDX_CR] = in_cr;

    generate
        for (genvar g = 0; g < N_SAMP; g++) begin : g_pad
            ycc422_justify u_just (
                .raw    (raw[g]),
                .depth  (depth_in),
                .padded (pad[g])
            );
        end
    endgenerate

    ycc422_chan_map u_map_first (
        .luma   (pad[IDX_Y0]),
        .chroma (pad[IDX_CB]),
        .word   (word_first)
    );

    ycc422_chan_map u_map_second (
        .luma   (hold_y1_q),
        .chroma (hold_cr_q),
        .word   (word_second)
    );

    assign in_ready = (phase_q == PH_FIRST);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_FIRST;
            out_valid <= 1'b0;
            out_phase <= 1'b0;
            out_sol   <= 1'b0;
            word_q    <= '0;
            hold_y1_q <= '0;
            hold_cr_q <= '0;
            err_odd   <= 1'b0;
        end else if (accept) begin
            phase_q   <= PH_SECOND;
            out_valid <= 1'b1;
            out_phase <= 1'b0;
            out_sol   <= in_sol;
            word_q    <= word_first;
            hold_y1_q <= in_single ? '0 : pad[IDX_Y1];
            hold_cr_q <= pad[IDX_CR];
            if (in_single) begin
                err_odd <= 1'b1;
            end
        end else if (phase_q == PH_SECOND) begin
            phase_q   <= PH_FIRST;
            out_valid <= 1'b1;
            out_phase <= 1'b1;
            out_sol   <= 1'b0;
            word_q    <= word_second;
        end else begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
        end
    end

    assign out_data = word_q;
endmodule

// File: rtl/ycc422_link_packer_chk.sv
module ycc422_link_packer_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic in_single,
    input logic out_valid,
    input logic out_phase,
    input logic out_sol,
    input logic err_odd
);
    AST_ACCEPT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !out_phase)); // R2

    AST_NO_READY_MID: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_phase) |-> !in_ready); // R2

    AST_SECOND_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_phase) |=> (out_valid && out_phase)); // R4

    AST_SINGLE_ERR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_single) |=> err_odd); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_odd |=> err_odd); // R7

    AST_SOL_FIRST: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> (out_valid && !out_phase)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !out_valid); // R9
endmodule

bind ycc422_link_packer ycc422_link_packer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_single (in_single),
    .out_valid (out_valid),
    .out_phase (out_phase),
    .out_sol   (out_sol),
    .err_odd   (err_odd)
);

// File: tb/ycc422_link_packer_tb.sv
module ycc422_link_packer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, in_sol, in_single;
    logic [1:0]  in_depth;
    logic [11:0] in_y0, in_y1, in_cb, in_cr;
    logic        out_valid, out_phase, out_sol, err_odd;
    logic [23:0] out_data;

    int total = 0;
    int bad   = 0;
    logic exp_err = 1'b0;

    always #2.5 clk = ~clk;

    ycc422_link_packer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sol(in_sol), .in_single(in_single), .in_depth(in_depth),
        .in_y0(in_y0), .in_y1(in_y1), .in_cb(in_cb), .in_cr(in_cr),
        .out_valid(out_valid), .out_phase(out_phase), .out_sol(out_sol),
        .out_data(out_data), .err_odd(err_odd)
    );

    function automatic logic [11:0] pad_ref(input logic [11:0] s, input logic [1:0] d);
        if (d == 2'd0) return {s[7:0], 4'h0};
        if (d == 2'd1) return {s[9:0], 2'b00};
        return s;
    endfunction

    function automatic logic [23:0] word_ref(input logic [11:0] l, input logic [11:0] c);
        return {c[11:4], l[11:4], c[3:0], l[3:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_err = 1'b0;
        #1;
        check("R1 out_valid", out_valid, 0);
        check("R1 out_sol", out_sol, 0);
        check("R1 err_odd", err_odd, 0);
        check("R1 in_ready", in_ready, 1);
    endtask

    task automatic send_pair(input logic [11:0] y0, input logic [11:0] y1,
                             input logic [11:0] cb, input logic [11:0] cr,
                             input logic [1:0] d, input logic sol, input logic single);
        logic [23:0] e1, e2;
        e1 = word_ref(pad_ref(y0, d), pad_ref(cb, d));
        e2 = word_ref(single ? 12'h000 : pad_ref(y1, d), pad_ref(cr, d));
        @(negedge clk);
        check("R2 ready before offer", in_ready, 1);
        in_valid = 1'b1; in_y0 = y0; in_y1 = y1; in_cb = cb; in_cr = cr;
        in_depth = d; in_sol = sol; in_single = single;
        @(posedge clk);
        #1;
        if (single) exp_err = 1'b1;
        check("R2 first valid", out_valid, 1);
        check("R2 first phase", out_phase, 0);
        check("R2 ready low mid", in_ready, 0);
        check("R3 R5 first word", out_data, e1);
        check("R8 sol", out_sol, sol);
        check("R6 R7 err", err_odd, exp_err);
        @(negedge clk);
        // dummy offer and depth change while second word is pending
        in_valid = 1'b1; in_y0 = $urandom; in_y1 = $urandom; in_cb = $urandom;
        in_cr = $urandom; in_depth = d + 2'd1; in_sol = 1'b1; in_single = 1'b1;
        @(posedge clk);
        #1;
        check("R2 second valid", out_valid, 1);
        check("R4 second phase", out_phase, 1);
        check("R4 R6 R10 second word", out_data, e2);
        check("R8 sol second", out_sol, 0);
        check("R2 ignored offer err", err_odd, exp_err);
        check("R2 ready back", in_ready, 1);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R9 idle", out_valid, 0);
    endtask

    initial begin
        #500000;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_4221));
        rst = 1'b1; in_valid = 1'b0; in_sol = 1'b0; in_single = 1'b0;
        in_depth = 2'd2; in_y0 = '0; in_y1 = '0; in_cb = '0; in_cr = '0;
        do_reset();

        // directed: 12-bit nibble split, R3 R4
        send_pair(12'hABC, 12'h123, 12'h456, 12'h789, 2'd2, 1'b1, 1'b0);
        go_idle();
        // directed: 8-bit with garbage upper bits, R5
        send_pair(12'hF5A, 12'hE3C, 12'hD77, 12'hC81, 2'd0, 1'b0, 1'b0);
        // back-to-back 10-bit, R9
        send_pair(12'hFFF, 12'h3FF, 12'h201, 12'h0AA, 2'd1, 1'b0, 1'b0);
        send_pair(12'h111, 12'h222, 12'h333, 12'h444, 2'd3, 1'b0, 1'b0);
        go_idle();
        check("R7 no err yet", err_odd, 0);

        // random stream
        for (int i = 0; i < 200; i++) begin
            send_pair($urandom, $urandom, $urandom, $urandom, 2'($urandom),
                      ($urandom % 4) == 0, ($urandom % 8) == 0);
            if (($urandom % 3) == 0) go_idle();
        end

        // directed odd line, then sticky
        send_pair(12'h5A5, 12'hFFF, 12'h0F0, 12'hF0F, 2'd2, 1'b1, 1'b1);
        go_idle();
        send_pair(12'h001, 12'h002, 12'h003, 12'h004, 2'd2, 1'b0, 1'b0);
        go_idle();
        check("R7 sticky", err_odd, 1);
        do_reset();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule